// File: doc/BRIEF.md
# Background Window Compositor

This block merges the character layer of an on-screen overlay with up to four rectangular background windows. Each pixel arrives with its character-cell position (row 0 to 14, column 0 to 29), a glyph-foreground bit, an edge bit and two candidate character colours. The edge bit comes from an upstream border or shadow generator, and it already encodes whether the edge wraps all four sides or only the right and bottom. The block decides which layer owns the pixel. It then drives a 3-bit RGB value and a fast-blank level, which an external video path uses to switch between its own picture and the overlay.

Window rectangles are counted in whole character cells. Each window has an enable bit, a 3-bit fill colour and a colour-select bit. The colour-select bit decides which of the two candidate colours a glyph takes when it sits on top of that window. A byte-wide write port loads the window descriptors and one control byte. The control byte switches the overlay on, chooses the fast-blank mode and polarity, and decides how the pads behave while the overlay is off.

All outputs are registered, so each pixel appears one clock after it is presented.

Top module: `osd_win_compositor`

## Requirements
- R1: Window w (0..3) is held in bytes at addresses 3w, 3w+1 and 3w+2.
  - Byte 3w holds row start in bits 7:4 and row end in bits 3:0.
  - Byte 3w+1 holds column start in bits 7:3, enable in bit 2 and colour-select in bit 1.
  - Byte 3w+2 holds column end in bits 7:3 and fill RGB in bits 2:0.
  - A cell is covered when the window is enabled and the cell lies inside both ranges, with both bounds inclusive.
- R2: A window whose row start exceeds its row end, or whose column start exceeds its column end, covers no cell, even when it is enabled.
- R3: Where covering windows overlap, the lowest-numbered window supplies the fill colour and the colour-select bit.
- R4: A glyph pixel outputs its second colour (clr2) when the winning covering window has colour-select 1. In every other case it outputs its first colour (clr1), including when no window covers the cell.
- R5: An edge pixel that is not a glyph pixel outputs black (000). It takes precedence over any window. A pixel that is neither glyph, edge nor covered outputs 000 with fast-blank inactive.
- R6: The control byte is at address 12. Writing it with bit 5 set clears the enable bit of all four windows. Bit 5 is not stored.
- R7: Control bit 2 selects the fast-blank mode.
  - With bit 2 = 0, fast-blank is active for glyph, edge and window pixels.
  - With bit 2 = 1, fast-blank is active for glyph and edge pixels only.
- R8: Control bit 1 forces fast-blank active while the overlay is on.
- R9: Control bit 3 sets the fast-blank polarity: 1 means active-high, 0 means active-low. After reset it is 1.
- R10: While control bit 0 (overlay on) is 0, RGB and fast-blank are driven 0. The pad enable output equals control bit 4: 1 means drive low, 0 means high impedance. While the overlay is on, the pad enable is 1.
- R11: Outputs reflect the pixel and configuration present one clock earlier. A write in the same cycle as a pixel affects only later pixels.
- R12: After reset, all window bytes are 0 and the control byte holds only bit 3. The outputs are therefore RGB 000, fast-blank 0 and pad enable 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte address (0..11 windows, 12 control) |
| cfg_wdata | input | 8 | Configuration write data |
| cell_row | input | 4 | Character row of the current pixel |
| cell_col | input | 5 | Character column of the current pixel |
| glyph_px | input | 1 | Glyph foreground pixel |
| edge_px | input | 1 | Border or shadow pixel from the edge generator |
| clr1 | input | 3 | Per-cell character colour |
| clr2 | input | 3 | Per-row alternate character colour |
| rgb_o | output | 3 | Composited colour |
| fblank_o | output | 1 | Fast-blank level |
| pad_oe_o | output | 1 | Output-pad enable for RGB and fast-blank |

## Verification
Two functions can fall in the same cycle:
- A descriptor or control write lands on the same clock as a pixel that the write would change. The bench presents a pixel inside a window while rewriting that window's enable byte, and again while rewriting the control byte. It expects the old result for that pixel and the new result on the next one.
- A glyph pixel can overlap two windows that carry different colour-select bits. Full-grid sweeps with glyph, edge and empty pixels are judged cell by cell against a behavioural model of window coverage and priority.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;

   // Bit positions in the control byte.
   localparam int CTL_OVL_BIT   = 0;
   localparam int CTL_FORCE_BIT = 1;
   localparam int CTL_CHARS_BIT = 2;
   localparam int CTL_POS_BIT   = 3;
   localparam int CTL_DRVLO_BIT = 4;
   localparam int CTL_CLR_BIT   = 5;

   typedef struct packed {
      logic drv_low;
      logic fb_pos;
      logic chars_only;
      logic force_fb;
      logic ovl_en;
   } ctl_t;

   typedef enum logic [1:0] {
      LAYER_NONE,
      LAYER_WIN,
      LAYER_EDGE,
      LAYER_GLYPH
   } layer_e;

endpackage

// File: rtl/osd_win_regs.sv
module osd_win_regs
   import osd_win_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int COL_W   = 5,
   parameter int ADDR_W  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [7:0]                      wdata,
   output logic [NUM_WIN-1:0][2:0][7:0]    desc_o,
   output ctl_t                            ctl_o
);
   localparam int EN_BIT   = 7 - COL_W;
   localparam int CTL_ADDR = 3 * NUM_WIN;

   logic               clr_cmd;
   logic [NUM_WIN-1:0] en_vec;

   assign clr_cmd = we && (addr == ADDR_W'(CTL_ADDR)) && wdata[CTL_CLR_BIT];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic [2:0][7:0] bytes_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bytes_q <= '0;
         end else begin
            for (int k = 0; k < 3; k++) begin
               if (we && (addr == ADDR_W'(3 * w + k))) begin
                  bytes_q[k] <= wdata;
               end
            end
            if (clr_cmd) begin
               bytes_q[1][EN_BIT] <= 1'b0;
            end
         end
      end

      assign desc_o[w] = bytes_q;
      assign en_vec[w] = bytes_q[1][EN_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_o <= '{drv_low: 1'b0, fb_pos: 1'b1, chars_only: 1'b0,
                    force_fb: 1'b0, ovl_en: 1'b0};
      end else if (we && (addr == ADDR_W'(CTL_ADDR))) begin
         ctl_o.ovl_en     <= wdata[CTL_OVL_BIT];
         ctl_o.force_fb   <= wdata[CTL_FORCE_BIT];
         ctl_o.chars_only <= wdata[CTL_CHARS_BIT];
         ctl_o.fb_pos     <= wdata[CTL_POS_BIT];
         ctl_o.drv_low    <= wdata[CTL_DRVLO_BIT];
      end
   end

   // R6
   clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |=> (en_vec == '0));

endmodule

// File: rtl/osd_win_hit.sv
module osd_win_hit #(
   parameter int ROW_W = 4,
   parameter int COL_W = 5,
   parameter int CLR_W = 3
) (
   input  logic [2:0][7:0]   desc,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   output logic              hit,
   output logic              ccs,
   output logic [CLR_W-1:0]  rgb
);
   logic [ROW_W-1:0] row_s, row_e;
   logic [COL_W-1:0] col_s, col_e;
   logic             en;
   logic             unused_bits;

   assign row_s = desc[0][7 -: ROW_W];
   assign row_e = desc[0][ROW_W-1:0];
   assign col_s = desc[1][7 -: COL_W];
   assign en    = desc[1][7 - COL_W];
   assign ccs   = desc[1][6 - COL_W];
   assign col_e = desc[2][7 -: COL_W];
   assign rgb   = desc[2][CLR_W-1:0];
   assign unused_bits = ^desc;

   // Inclusive bounds; start above end leaves the range empty.
   assign hit = en && (row >= row_s) && (row <= row_e)
                   && (col >= col_s) && (col <= col_e);

endmodule

// File: rtl/osd_win_prio.sv
module osd_win_prio #(
   parameter int NUM_WIN = 4,
   parameter int CLR_W   = 3
) (
   input  logic [NUM_WIN-1:0]            hit,
   input  logic [NUM_WIN-1:0]            ccs,
   input  logic [NUM_WIN-1:0][CLR_W-1:0] rgb,
   output logic                          any_hit,
   output logic                          sel_ccs,
   output logic [CLR_W-1:0]              sel_rgb
);
   // Scan from the weakest window up, so the lowest index is applied last.
   always_comb begin
      any_hit = 1'b0;
      sel_ccs = 1'b0;
      sel_rgb = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hit[w]) begin
            any_hit = 1'b1;
            sel_ccs = ccs[w];
            sel_rgb = rgb[w];
         end
      end
   end

endmodule

// File: rtl/osd_win_compositor.sv
module osd_win_compositor
   import osd_win_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int ROW_W   = 4,
   parameter int COL_W   = 5,
   parameter int CLR_W   = 3,
   localparam int ADDR_W = $clog2(3 * NUM_WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic [ROW_W-1:0]  cell_row,
   input  logic [COL_W-1:0]  cell_col,
   input  logic              glyph_px,
   input  logic              edge_px,
   input  logic [CLR_W-1:0]  clr1,
   input  logic [CLR_W-1:0]  clr2,
   output logic [CLR_W-1:0]  rgb_o,
   output logic              fblank_o,
   output logic              pad_oe_o
);
   if ((2 * ROW_W > 8) || (COL_W + 2 > 8) || (COL_W + CLR_W > 8) || (NUM_WIN < 1)) begin : g_bad_cfg
      $error("osd_win_compositor: field widths do not fit the byte layout");
   end

   logic [NUM_WIN-1:0][2:0][7:0]    desc;
   ctl_t                            ctl;
   logic [NUM_WIN-1:0]              w_hit;
   logic [NUM_WIN-1:0]              w_ccs;
   logic [NUM_WIN-1:0][CLR_W-1:0]   w_rgb;
   logic                            any_hit;
   logic                            sel_ccs;
   logic [CLR_W-1:0]                sel_rgb;
   layer_e                          layer;
   logic [CLR_W-1:0]                rgb_n;
   logic                            act_n;

   osd_win_regs #(.NUM_WIN(NUM_WIN), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .desc_o (desc),
      .ctl_o  (ctl)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_hit
      osd_win_hit #(.ROW_W(ROW_W), .COL_W(COL_W), .CLR_W(CLR_W)) u_hit (
         .desc (desc[w]),
         .row  (cell_row),
         .col  (cell_col),
         .hit  (w_hit[w]),
         .ccs  (w_ccs[w]),
         .rgb  (w_rgb[w])
      );
   end

   osd_win_prio #(.NUM_WIN(NUM_WIN), .CLR_W(CLR_W)) u_prio (
      .hit     (w_hit),
      .ccs     (w_ccs),
      .rgb     (w_rgb),
      .any_hit (any_hit),
      .sel_ccs (sel_ccs),
      .sel_rgb (sel_rgb)
   );

   always_comb begin
      if (glyph_px)      layer = LAYER_GLYPH;
      else if (edge_px)  layer = LAYER_EDGE;
      else if (any_hit)  layer = LAYER_WIN;
      else               layer = LAYER_NONE;

      unique case (layer)
         LAYER_GLYPH: begin
            rgb_n = (any_hit && sel_ccs) ? clr2 : clr1;
            act_n = 1'b1;
         end
         LAYER_EDGE: begin
            rgb_n = '0;
            act_n = 1'b1;
         end
         LAYER_WIN: begin
            rgb_n = sel_rgb;
            act_n = !ctl.chars_only;
         end
         default: begin
            rgb_n = '0;
            act_n = 1'b0;
         end
      endcase
      if (ctl.force_fb) act_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rgb_o    <= '0;
         fblank_o <= 1'b0;
         pad_oe_o <= 1'b0;
      end else if (!ctl.ovl_en) begin
         rgb_o    <= '0;
         fblank_o <= 1'b0;
         pad_oe_o <= ctl.drv_low;
      end else begin
         rgb_o    <= rgb_n;
         fblank_o <= act_n ^ !ctl.fb_pos;
         pad_oe_o <= 1'b1;
      end
   end

   // R10
   ovl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.ovl_en |=> (rgb_o == '0) && !fblank_o && (pad_oe_o == $past(ctl.drv_low)));

   // R8
   force_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.ovl_en && ctl.force_fb) |=> (fblank_o == $past(ctl.fb_pos)));

   // R5
   edge_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.ovl_en && edge_px && !glyph_px) |=> (rgb_o == '0));

   // R9
   glyph_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.ovl_en && glyph_px) |=> (fblank_o == $past(ctl.fb_pos)));

endmodule

// File: tb/osd_win_compositor_tb.sv
module osd_win_compositor_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [3:0] cell_row = '0;
   logic [4:0] cell_col = '0;
   logic       glyph_px = 1'b0;
   logic       edge_px = 1'b0;
   logic [2:0] clr1 = '0;
   logic [2:0] clr2 = '0;
   logic [2:0] rgb_o;
   logic       fblank_o;
   logic       pad_oe_o;

   always #2 clk = ~clk;

   osd_win_compositor u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cell_row  (cell_row),
      .cell_col  (cell_col),
      .glyph_px  (glyph_px),
      .edge_px   (edge_px),
      .clr1      (clr1),
      .clr2      (clr2),
      .rgb_o     (rgb_o),
      .fblank_o  (fblank_o),
      .pad_oe_o  (pad_oe_o)
   );

   // Behavioural reference state.
   int    m_byte [12];
   int    m_ovl, m_force, m_chars, m_pos, m_drvlo;
   int    n_vec = 0;
   int    n_bad = 0;
   int    have_exp = 0;
   int    exp_val = 0;
   string exp_tag = "";
   int    cyc = 0;
   int    done = 0;

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && done == 0) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
         finish_run();
      end
   end

   function automatic int model(int r, int c, int g, int e, int c1, int c2);
      int top, tccs, trgb, rgb, act, fb;
      if (m_ovl == 0) return (0 << 2) | (0 << 1) | m_drvlo;
      top = -1; tccs = 0; trgb = 0;
      for (int w = 0; w < 4; w++) begin
         int rs, re, cs, ce, en;
         rs = (m_byte[3*w] >> 4) & 15;
         re = m_byte[3*w] & 15;
         cs = (m_byte[3*w+1] >> 3) & 31;
         en = (m_byte[3*w+1] >> 2) & 1;
         ce = (m_byte[3*w+2] >> 3) & 31;
         if (top < 0 && en == 1 && r >= rs && r <= re && c >= cs && c <= ce) begin
            top  = w;
            tccs = (m_byte[3*w+1] >> 1) & 1;
            trgb = m_byte[3*w+2] & 7;
         end
      end
      if (g != 0) begin
         rgb = (top >= 0 && tccs == 1) ? c2 : c1;
         act = 1;
      end else if (e != 0) begin
         rgb = 0; act = 1;
      end else if (top >= 0) begin
         rgb = trgb; act = (m_chars == 0) ? 1 : 0;
      end else begin
         rgb = 0; act = 0;
      end
      if (m_force != 0) act = 1;
      fb = (m_pos != 0) ? act : 1 - act;
      return (rgb << 2) | (fb << 1) | 1;
   endfunction

   task automatic model_write(int addr, int data);
      if (addr < 12) m_byte[addr] = data & 255;
      else if (addr == 12) begin
         m_ovl   = data & 1;
         m_force = (data >> 1) & 1;
         m_chars = (data >> 2) & 1;
         m_pos   = (data >> 3) & 1;
         m_drvlo = (data >> 4) & 1;
         if (((data >> 5) & 1) != 0) begin
            for (int w = 0; w < 4; w++) m_byte[3*w+1] = m_byte[3*w+1] & ~4;
         end
      end
   endtask

   task automatic compare();
      int got;
      got = {27'd0, rgb_o, fblank_o, pad_oe_o};
      n_vec++;
      if (got != exp_val) begin
         n_bad++;
         $display("FAIL %s: actual rgb/fb/oe=%b expected=%b", exp_tag, got[4:0], exp_val[4:0]);
      end
   endtask

   // One pixel plus an optional write per clock; checks the previous pixel.
   task automatic step(int r, int c, int g, int e, int c1, int c2,
                       int we, int addr, int data, string tag);
      @(negedge clk);
      if (have_exp != 0) compare();
      cell_row  = 4'(r);
      cell_col  = 5'(c);
      glyph_px  = (g != 0);
      edge_px   = (e != 0);
      clr1      = 3'(c1);
      clr2      = 3'(c2);
      cfg_we    = (we != 0);
      cfg_addr  = 4'(addr);
      cfg_wdata = 8'(data);
      exp_val   = model(r, c, g, e, c1, c2);
      exp_tag   = tag;
      have_exp  = 1;
      if (we != 0) model_write(addr, data);
   endtask

   task automatic wr(int addr, int data, string tag);
      step(0, 0, 0, 0, 0, 0, 1, addr, data, tag);
   endtask

   task automatic sweep(int g, int e, int c1, int c2, string tag);
      for (int r = 0; r < 15; r++)
         for (int c = 0; c < 30; c++)
            step(r, c, g, e, c1, c2, 0, 0, 0, tag);
   endtask

   initial begin
      for (int i = 0; i < 12; i++) m_byte[i] = 0;
      m_ovl = 0; m_force = 0; m_chars = 0; m_pos = 1; m_drvlo = 0;

      // R12: reset state
      repeat (3) begin
         @(negedge clk);
         exp_val = 0; exp_tag = "R12";
         compare();
      end
      rst_n = 1'b1;

      // R12: idle after reset, overlay off, pads high impedance
      step(3, 4, 1, 0, 7, 7, 0, 0, 0, "R12");
      step(3, 4, 0, 1, 7, 7, 0, 0, 0, "R12");

      // R10: overlay off but pads driven low
      wr(12, 8'h18, "R10");
      step(2, 5, 1, 0, 5, 6, 0, 0, 0, "R10");
      step(2, 5, 1, 0, 5, 6, 0, 0, 0, "R10");

      // R1 window 0: rows 2..5 cols 3..10, rgb 5, ccs 1
      wr(0, 8'h25, "R1"); wr(1, 8'h1E, "R1"); wr(2, 8'h55, "R1");
      // R3 window 1: rows 4..8 cols 8..20, rgb 2, ccs 0, overlaps window 0
      wr(3, 8'h48, "R3"); wr(4, 8'h44, "R3"); wr(5, 8'hA2, "R3");
      // R2 window 2: rows 9>3, enabled, cols 0..29
      wr(6, 8'h93, "R2"); wr(7, 8'h04, "R2"); wr(8, 8'hEB, "R2");
      // R2 window 3: rows 0..14, cols 20>5, enabled
      wr(9, 8'h0E, "R2"); wr(10, 8'hA4, "R2"); wr(11, 8'h2E, "R2");
      // overlay on, positive polarity
      wr(12, 8'h09, "R1");

      sweep(0, 0, 0, 0, "R1");            // R1 R2 R3 coverage and priority
      sweep(1, 0, 1, 6, "R4");            // glyph colour select
      sweep(0, 1, 3, 4, "R5");            // edge pixels black
      sweep(1, 1, 2, 7, "R5");            // glyph above edge

      // R7: chars-only fast-blank
      wr(12, 8'h0D, "R7");
      sweep(0, 0, 0, 0, "R7");
      step(4, 9, 0, 1, 0, 0, 0, 0, 0, "R7");

      // R8: forced fast-blank
      wr(12, 8'h0B, "R8");
      step(14, 29, 0, 0, 0, 0, 0, 0, 0, "R8");
      step(3, 4, 0, 0, 0, 0, 0, 0, 0, "R8");

      // R9: negative polarity
      wr(12, 8'h01, "R9");
      sweep(0, 0, 0, 0, "R9");
      step(6, 12, 1, 0, 3, 3, 0, 0, 0, "R9");

      // R11: write in the same cycle as a covered pixel applies afterwards
      wr(12, 8'h09, "R11");
      step(3, 4, 0, 0, 0, 0, 1, 1, 8'h18, "R11");   // disable window 0 here
      step(3, 4, 0, 0, 0, 0, 0, 0, 0, "R11");
      step(3, 4, 1, 0, 1, 6, 1, 1, 8'h1E, "R11");   // re-enable window 0
      step(3, 4, 1, 0, 1, 6, 0, 0, 0, "R11");
      step(5, 9, 0, 0, 0, 0, 1, 12, 8'h00, "R11");  // overlay off same cycle
      step(5, 9, 0, 0, 0, 0, 0, 0, 0, "R11");

      // R6: clear all enables, then confirm no window remains
      wr(12, 8'h29, "R6");
      sweep(0, 0, 0, 0, "R6");
      step(5, 9, 1, 0, 1, 6, 0, 0, 0, "R6");

      // R10: overlay off, high impedance
      wr(12, 8'h08, "R10");
      step(5, 9, 1, 0, 1, 6, 0, 0, 0, "R10");
      step(5, 9, 0, 0, 0, 0, 0, 0, 0, "R10");

      @(negedge clk);
      compare();
      finish_run();
   end

endmodule